// File: doc/BRIEF.md
# Single-Step Shift Register with Signed Overflow Flag

This block is one W-bit data register with a small shifter in front of it. On each clock where shifting is enabled, it moves the register contents by exactly one position. A 3-bit operation code selects the direction and how the vacated end is filled: zero fill (logical), wrap-around (rotate), or sign-aware (arithmetic). A parallel load path writes a new value into the register, and this path wins over any shift request.

Each shift also records the bit that left the register in a one-bit serial-out flag. The signed overflow flag is updated only by an arithmetic left shift. It is set when that shift would flip the sign of the value, and it is cleared by every other shift. Bits are numbered from 0 at the right up to W-1 at the left, and bit W-1 is the sign.

Top module: `sh_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `q`, `sout` and `ovf` to 0.
- R2: With `ld` high, `q` takes `ld_val` on the next edge, whatever `sh_en` and `op` are. `sout` and `ovf` keep their values.
- R3: With `ld` low and either `sh_en` low or `op` equal to 3'b110 or 3'b111, `q`, `sout` and `ovf` hold their values.
- R4: Op 3'b000 (logical left): new `q` is old `q` moved up one place with 0 in bit 0. `sout` takes old bit W-1.
- R5: Op 3'b001 (logical right): new `q` is old `q` moved down one place with 0 in bit W-1. `sout` takes old bit 0.
- R6: Op 3'b010 (rotate left): old bit W-1 goes into bit 0. `sout` takes old bit W-1.
- R7: Op 3'b011 (rotate right): old bit 0 goes into bit W-1. `sout` takes old bit 0.
- R8: Op 3'b100 (arithmetic left): `q` moves up one place with 0 in bit 0, and `sout` takes old bit W-1. `ovf` becomes old bit W-1 XOR old bit W-2, so it is 1 exactly when the sign flips.
- R9: Op 3'b101 (arithmetic right): bit W-1 keeps its old value and is also copied into bit W-2. The remaining bits move down one place, and `sout` takes old bit 0.
- R10: Every enabled shift with op 3'b000, 3'b001, 3'b010, 3'b011 or 3'b101 clears `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | Parallel load strobe, has priority over shifting |
| ld_val | input | W | Value written on load |
| sh_en | input | 1 | Enables a one-place shift |
| op | input | 3 | Shift kind and direction |
| q | output | W | Register contents |
| sout | output | 1 | Last bit shifted out |
| ovf | output | 1 | Signed overflow from the last arithmetic left shift |

## Verification
The bench builds two instances side by side and drives both with the same stimulus: the default width of 8, and the minimum width of 2. With W=2 the sign bit and the bit that feeds the overflow test are the only two bits in the register. That makes every edge-fill path collide with its neighbour, and a short random run covers every sign transition. The W=8 instance receives directed loads of the most-negative value 0x80, the most-positive value 0x7F, and 0x40 and 0xC0, followed by arithmetic shifts. This shows overflow both being raised and staying clear.

// File: rtl/sh_pkg.sv
package sh_pkg;

    typedef enum logic [2:0] {
        OP_LSL  = 3'b000,
        OP_LSR  = 3'b001,
        OP_ROL  = 3'b010,
        OP_ROR  = 3'b011,
        OP_ASL  = 3'b100,
        OP_ASR  = 3'b101,
        OP_NOP6 = 3'b110,
        OP_NOP7 = 3'b111
    } sh_op_e;

    function automatic logic is_left(sh_op_e o);
        return (o == OP_LSL) || (o == OP_ROL) || (o == OP_ASL);
    endfunction

    function automatic logic is_right(sh_op_e o);
        return (o == OP_LSR) || (o == OP_ROR) || (o == OP_ASR);
    endfunction

endpackage

// File: rtl/sh_fill_sel.sv
// Chooses the bit entering each end of the register for the given op.
module sh_fill_sel
    import sh_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  sh_op_e       op,
    output logic         lo_in,
    output logic         hi_in
);
    always_comb begin
        lo_in = 1'b0;
        hi_in = 1'b0;
        unique case (op)
            OP_ROL:  lo_in = cur[W-1];
            OP_ROR:  hi_in = cur[0];
            OP_ASR:  hi_in = cur[W-1];
            default: begin
                lo_in = 1'b0;
                hi_in = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sh_step.sv
// Both one-place shift results, built bit by bit.
module sh_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         lo_in,
    input  logic         hi_in,
    output logic [W-1:0] up,
    output logic [W-1:0] down
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign up[i] = lo_in;
        end else begin : g_lo_mid
            assign up[i] = cur[i-1];
        end
        if (i == W-1) begin : g_hi
            assign down[i] = hi_in;
        end else begin : g_hi_mid
            assign down[i] = cur[i+1];
        end
    end
endmodule

// File: rtl/sh_sign_flip.sv
// Flags whether a left move changes the sign of the value.
module sh_sign_flip #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    output logic         flip
);
    localparam int SGN = W - 1;
    localparam int NXT = W - 2;
    assign flip = cur[SGN] ^ cur[NXT];
endmodule

// File: rtl/sh_unit.sv
module sh_unit
    import sh_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         sh_en,
    input  logic [2:0]   op,
    output logic [W-1:0] q,
    output logic         sout,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         so;
        logic         vf;
    } st_t;

    st_t          st_d, st_q;
    sh_op_e       op_e;
    logic         lo_in, hi_in, flip;
    logic [W-1:0] up_res, down_res;

    assign op_e = sh_op_e'(op);

    sh_fill_sel #(.W(W)) u_fill (
        .cur   (st_q.data),
        .op    (op_e),
        .lo_in (lo_in),
        .hi_in (hi_in)
    );

    sh_step #(.W(W)) u_step (
        .cur   (st_q.data),
        .lo_in (lo_in),
        .hi_in (hi_in),
        .up    (up_res),
        .down  (down_res)
    );

    sh_sign_flip #(.W(W)) u_flip (
        .cur  (st_q.data),
        .flip (flip)
    );

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.data = ld_val;
        end else if (sh_en) begin
            if (is_left(op_e)) begin
                st_d.data = up_res;
                st_d.so   = st_q.data[W-1];
                st_d.vf   = (op_e == OP_ASL) ? flip : 1'b0;
            end else if (is_right(op_e)) begin
                st_d.data = down_res;
                st_d.so   = st_q.data[0];
                st_d.vf   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q    = st_q.data;
    assign sout = st_q.so;
    assign ovf  = st_q.vf;
endmodule

// File: rtl/sh_unit_chk.sv
module sh_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ld,
    input logic [W-1:0] ld_val,
    input logic         sh_en,
    input logic [2:0]   op,
    input logic [W-1:0] q,
    input logic         sout,
    input logic         ovf
);
    logic act;
    assign act = !ld && sh_en;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (q == '0 && !sout && !ovf));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(ld_val) && $stable(sout) && $stable(ovf)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ld && (!sh_en || op[2:1] == 2'b11)) |=> ($stable(q) && $stable(sout) && $stable(ovf)));

    p_zero_in_r4: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b000) |=> (q[0] == 1'b0 && sout == $past(q[W-1])));

    p_rotate_r6: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b010) |=> (q == {$past(q[W-2:0]), $past(q[W-1])}));

    p_flip_r8: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b100) |=> (ovf == ($past(q[W-1]) != $past(q[W-2]))));

    p_sign_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b101) |=> (q[W-1] == $past(q[W-1]) && q[W-2] == $past(q[W-1])));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (act && op != 3'b100 && op[2:1] != 2'b11) |=> !ovf);
endmodule

bind sh_unit sh_unit_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ld     (ld),
    .ld_val (ld_val),
    .sh_en  (sh_en),
    .op     (op),
    .q      (q),
    .sout   (sout),
    .ovf    (ovf)
);

// File: tb/sh_unit_tb.sv
`timescale 1ns/1ps
module sh_unit_tb;
    logic       clk = 1'b0;
    logic       rst, ld, sh_en;
    logic [7:0] ld_val;
    logic [2:0] op;
    logic [7:0] q8;
    logic [1:0] q2;
    logic       so8, so2, v8, v2;
    int total = 0, bad = 0;
    logic done = 1'b0;

    logic [15:0] mq8, mq2;
    logic        ms8, ms2, mv8, mv2;
    string       tag, vtag;

    always #2.5 clk = ~clk;

    sh_unit #(.W(8)) u_dut (
        .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_val), .sh_en(sh_en),
        .op(op), .q(q8), .sout(so8), .ovf(v8));

    sh_unit #(.W(2)) u_dut2 (
        .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_val[1:0]), .sh_en(sh_en),
        .op(op), .q(q2), .sout(so2), .ovf(v2));

    // Behavioural reference for width w (w <= 16).
    function automatic void model(int w, logic r, logic l, logic [15:0] lv,
                                  logic e, logic [2:0] o,
                                  inout logic [15:0] mq, inout logic ms, inout logic mv);
        logic [15:0] m;
        logic msb, lsb;
        m   = 16'((32'd1 << w) - 1);
        msb = mq[w-1];
        lsb = mq[0];
        if (r) begin
            mq = '0; ms = 0; mv = 0;
        end else if (l) begin
            mq = lv & m;
        end else if (e) begin
            case (o)
                3'd0: begin ms = msb; mq = (mq << 1) & m; mv = 0; end
                3'd1: begin ms = lsb; mq = mq >> 1; mv = 0; end
                3'd2: begin ms = msb; mq = ((mq << 1) | 16'(msb)) & m; mv = 0; end
                3'd3: begin ms = lsb; mq = (mq >> 1) | (16'(lsb) << (w-1)); mv = 0; end
                3'd4: begin ms = msb; mv = msb ^ mq[w-2]; mq = (mq << 1) & m; end
                3'd5: begin ms = lsb; mq = (mq >> 1) | (16'(msb) << (w-1)); mv = 0; end
                default: ;
            endcase
        end
    endfunction

    task automatic chk(string t, string what, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h at %0t", t, what, got, exp, $time);
        end
    endtask

    task automatic cyc(logic r, logic l, logic [7:0] lv, logic e, logic [2:0] o);
        rst = r; ld = l; ld_val = lv; sh_en = e; op = o;
        if (r)                           begin tag = "R1"; vtag = "R1"; end
        else if (l)                      begin tag = "R2"; vtag = "R2"; end
        else if (!e || o[2:1] == 2'b11)  begin tag = "R3"; vtag = "R3"; end
        else begin
            case (o)
                3'd0: tag = "R4";
                3'd1: tag = "R5";
                3'd2: tag = "R6";
                3'd3: tag = "R7";
                3'd4: tag = "R8";
                default: tag = "R9";
            endcase
            vtag = (o == 3'd4) ? "R8" : "R10";
        end
        model(8, r, l, {8'h0, lv}, e, o, mq8, ms8, mv8);
        model(2, r, l, {14'h0, lv[1:0]}, e, o, mq2, ms2, mv2);
        @(negedge clk);
        chk(tag,  "q(W8)",    {8'h0, q8},  mq8);
        chk(tag,  "sout(W8)", {15'h0, so8}, {15'h0, ms8});
        chk(vtag, "ovf(W8)",  {15'h0, v8},  {15'h0, mv8});
        chk(tag,  "q(W2)",    {14'h0, q2}, mq2);
        chk(tag,  "sout(W2)", {15'h0, so2}, {15'h0, ms2});
        chk(vtag, "ovf(W2)",  {15'h0, v2},  {15'h0, mv2});
    endtask

    initial begin
        mq8 = '0; mq2 = '0; ms8 = 0; ms2 = 0; mv8 = 0; mv2 = 0;
        rst = 1; ld = 0; ld_val = 0; sh_en = 0; op = 0;
        @(negedge clk);
        cyc(1, 0, 8'h00, 0, 3'd0);            // R1 reset state
        cyc(1, 1, 8'hFF, 1, 3'd2);            // R1 reset beats load
        cyc(0, 1, 8'h80, 1, 3'd0);            // R2 most-negative, load beats shift
        cyc(0, 0, 8'h00, 1, 3'd4);            // R8 sign flips: overflow
        cyc(0, 0, 8'h00, 0, 3'd4);            // R3 disabled, flag kept
        cyc(0, 1, 8'h80, 0, 3'd0);            // R2
        cyc(0, 0, 8'h00, 1, 3'd5);            // R9 0x80 -> 0xC0
        cyc(0, 0, 8'h00, 1, 3'd5);            // R9 -> 0xE0
        cyc(0, 1, 8'h7F, 0, 3'd0);            // R2 most-positive
        cyc(0, 0, 8'h00, 1, 3'd4);            // R8 overflow
        cyc(0, 0, 8'h00, 1, 3'd1);            // R5 and R10 clear
        cyc(0, 1, 8'hC0, 0, 3'd0);
        cyc(0, 0, 8'h00, 1, 3'd4);            // R8 no flip: 1^1
        cyc(0, 1, 8'h40, 0, 3'd0);
        cyc(0, 0, 8'h00, 1, 3'd4);            // R8 0x40 -> 0x80 flips
        cyc(0, 0, 8'h00, 1, 3'd6);            // R3 reserved op holds
        cyc(0, 0, 8'h00, 1, 3'd7);            // R3 reserved op holds
        cyc(0, 0, 8'h00, 1, 3'd2);            // R6 rotate left, R10 clears
        cyc(0, 1, 8'h81, 0, 3'd0);
        cyc(0, 0, 8'h00, 1, 3'd3);            // R7 rotate right
        cyc(0, 0, 8'h00, 1, 3'd0);            // R4 logical left
        cyc(0, 0, 8'h00, 1, 3'd1);            // R5 logical right
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom_range(0, 99) == 0), ($urandom_range(0, 7) == 0),
                8'($urandom), ($urandom_range(0, 5) != 0), 3'($urandom));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule